// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block produces a single-cycle clock-enable strobe that fires on a fixed fraction of clock cycles, M out of N, so that slow logic can run from the main clock without a derived or gated clock. The fraction is set by a preset bit pattern held in an N-bit ring. The ring turns one place per clock, and the bit that reaches the low end is registered as the strobe. Because the pattern can place its ones anywhere, the average division ratio need not be an integer: the default pattern gives 2 pulses every 9 cycles.

A counter inside the block advances only on cycles where the strobe is high. It stands in for the downstream logic that would use the enable, and it stays in the same clock domain as the strobe. The ring width, its preset pattern and the counter width are parameters.

Top module: `frac_strobe_gen`

## Requirements
- R1: A synchronous reset loads the ring with the preset pattern (default 9 bits, value 9'b100010000, so bits 8 and 4 are set).
- R2: On every clock edge out of reset the ring turns toward its low end by one place: bit 0 moves to the top bit and each other bit moves down one position.
- R3: `strobe_o` is the value ring bit 0 held before the current edge. With the default pattern the strobe is high after the 5th and 9th edges following reset release, and then every 9 edges after each of those.
- R4: `count_o` increases by one on an edge only when `strobe_o` was high before that edge, and keeps its value otherwise.
- R5: While reset is high, both `strobe_o` and `count_o` become 0 on the next edge.
- R6: Any 9 consecutive strobe samples taken after reset release hold exactly 2 high cycles with the default pattern, i.e. as many as the preset pattern has ones.
- R7: The counter wraps from its all-ones value (255 for 8 bits) to 0 on the next enabled edge.
- R8: A reset applied in mid-run restarts the pattern at its initial phase, so the first pulse after release again follows the 5th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_o | output | 1 | Registered clock-enable strobe |
| count_o | output | CNT_W (8) | Counter that advances on strobe cycles |

## Verification
Every result has exactly one register between its cause and the port. The strobe follows ring bit 0 by one edge, and the count follows the strobe by one edge, so the first pulse shows after the 5th edge and the first count step after the 6th. Inputs change on the falling edge, and outputs are sampled on the next falling edge, half a period after the edge that updated them. The expected sequence comes from the preset pattern indexed by the edge number since reset release. A reset applied for a single edge is likewise checked on the following falling edge.

// File: rtl/frac_strobe_pkg.sv
package frac_strobe_pkg;

    // Default ring geometry: 2 enables in every 9 cycles
    localparam int          DEF_RING_W    = 9;
    localparam logic [8:0]  DEF_RING_INIT = 9'b100010000;
    localparam int          DEF_CNT_W     = 8;

    // Number of set bits in a pattern of up to 64 bits
    function automatic int ones_in(input logic [63:0] v, input int w);
        int n;
        n = 0;
        for (int i = 0; i < w; i++) begin
            if (v[i]) n++;
        end
        return n;
    endfunction

    // Next-state record for the strobe stage
    typedef struct packed {
        logic load;     // reset request
        logic tap;      // ring bit leaving position 0
    } strobe_ctl_t;

endpackage

// File: rtl/strobe_ring.sv
module strobe_ring #(
    parameter int               RING_W    = frac_strobe_pkg::DEF_RING_W,
    parameter logic [RING_W-1:0] RING_INIT = RING_W'(frac_strobe_pkg::DEF_RING_INIT)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [RING_W-1:0] ring_q,
    output logic              tap_o
);

    logic [RING_W-1:0] ring_d;

    // Each bit takes the value of its upper neighbour; the top takes bit 0
    generate
        for (genvar i = 0; i < RING_W; i++) begin : g_bit
            if (i == RING_W - 1) begin : g_top
                assign ring_d[i] = ring_q[0];
            end else begin : g_mid
                assign ring_d[i] = ring_q[i+1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ring_q <= RING_INIT;
        else     ring_q <= ring_d;
    end

    assign tap_o = ring_q[0];

endmodule

// File: rtl/strobe_reg.sv
module strobe_reg
    import frac_strobe_pkg::*;
(
    input  logic        clk,
    input  strobe_ctl_t ctl,
    output logic        strobe_q
);

    always_ff @(posedge clk) begin
        if (ctl.load) strobe_q <= 1'b0;
        else          strobe_q <= ctl.tap;
    end

endmodule

// File: rtl/gated_counter.sv
module gated_counter #(
    parameter int CNT_W = frac_strobe_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst)     cnt_q <= '0;
        else if (en) cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen
    import frac_strobe_pkg::*;
#(
    parameter int                RING_W    = DEF_RING_W,
    parameter logic [RING_W-1:0] RING_INIT = RING_W'(DEF_RING_INIT),
    parameter int                CNT_W     = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic             strobe_o,
    output logic [CNT_W-1:0] count_o
);

    logic [RING_W-1:0] ring_q;
    logic              tap;
    strobe_ctl_t       ctl;

    strobe_ring #(
        .RING_W    (RING_W),
        .RING_INIT (RING_INIT)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .ring_q (ring_q),
        .tap_o  (tap)
    );

    assign ctl = '{load: rst, tap: tap};

    strobe_reg u_stb (
        .clk      (clk),
        .ctl      (ctl),
        .strobe_q (strobe_o)
    );

    gated_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (strobe_o),
        .cnt_q (count_o)
    );

endmodule

// File: rtl/frac_strobe_chk.sv
module frac_strobe_chk #(
    parameter int                RING_W    = 9,
    parameter logic [RING_W-1:0] RING_INIT = 9'b100010000,
    parameter int                CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RING_W-1:0] ring,
    input  logic              strobe,
    input  logic [CNT_W-1:0]  count
);

    localparam int ONES = frac_strobe_pkg::ones_in(64'(RING_INIT), RING_W);

    AST_RESET_LOAD: assert property (@(posedge clk) rst |=> ring == RING_INIT); // R1
    AST_RING_TURN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ring == {$past(ring[0]), $past(ring[RING_W-1:1])}); // R2
    AST_STROBE_TAP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> strobe == $past(ring[0])); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(count)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        strobe |=> count == $past(count) + CNT_W'(1)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!strobe && count == '0)); // R5
    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(ring) == ONES); // R6

endmodule

bind frac_strobe_gen frac_strobe_chk #(
    .RING_W    (RING_W),
    .RING_INIT (RING_INIT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ring   (ring_q),
    .strobe (strobe_o),
    .count  (count_o)
);

// File: tb/sim_frac_strobe_gen.sv
`timescale 1ns/1ps
module sim_frac_strobe_gen;

    localparam logic [8:0] INIT = 9'b100010000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_o;
    logic [7:0] count_o;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    frac_strobe_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .strobe_o (strobe_o),
        .count_o  (count_o)
    );

    // {strobe, count} expected after edges 1..18 following reset release
    localparam logic [8:0] TABLE [18] = '{
        {1'b0, 8'd0}, {1'b0, 8'd0}, {1'b0, 8'd0}, {1'b0, 8'd0}, {1'b1, 8'd0},
        {1'b0, 8'd1}, {1'b0, 8'd1}, {1'b0, 8'd1}, {1'b1, 8'd1},
        {1'b0, 8'd2}, {1'b0, 8'd2}, {1'b0, 8'd2}, {1'b0, 8'd2}, {1'b1, 8'd2},
        {1'b0, 8'd3}, {1'b0, 8'd3}, {1'b0, 8'd3}, {1'b1, 8'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        bit       exp_s, prev_s, wrap_seen;
        int       exp_c, k, hist_n;
        bit [8:0] hist;
        wrap_seen = 1'b0;
        hist = '0;
        hist_n = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(strobe_o == 1'b0, "R5 strobe", strobe_o, 0);
        chk(count_o == 8'd0, "R5 count", count_o, 0);
        rst = 1'b0;

        // Table walk: R1 preset, R2 rotation, R3 strobe phase, R4 counting
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            chk(strobe_o == TABLE[i][8], "R3 strobe", strobe_o, TABLE[i][8]);
            chk(count_o == TABLE[i][7:0], "R4 count", count_o, TABLE[i][7:0]);
            hist = {hist[7:0], strobe_o};
            hist_n++;
        end

        // Long run past counter wrap, with 9-cycle window check (R6, R7)
        exp_c  = 3;
        prev_s = 1'b1;
        for (int kk = 19; kk <= 1300; kk++) begin
            k = kk;
            @(negedge clk);
            exp_s = INIT[(k - 1) % 9];
            if (prev_s) begin
                if (exp_c == 255) wrap_seen = 1'b1;
                exp_c = (exp_c + 1) % 256;
            end
            chk(strobe_o == exp_s, "R2 strobe", strobe_o, exp_s);
            chk(count_o == 8'(exp_c), "R7 count", count_o, exp_c);
            hist = {hist[7:0], strobe_o};
            hist_n++;
            if (hist_n >= 9)
                chk($countones(hist) == 2, "R6 window", $countones(hist), 2);
            prev_s = exp_s;
        end
        chk(wrap_seen, "R7 wrap reached", wrap_seen, 1);

        // Mid-run reset (R5, R8)
        rst = 1'b1;
        @(negedge clk);
        chk(strobe_o == 1'b0, "R8 strobe after reset", strobe_o, 0);
        chk(count_o == 8'd0, "R5 count after reset", count_o, 0);
        rst = 1'b0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk(strobe_o == TABLE[i][8], "R8 restart phase", strobe_o, TABLE[i][8]);
            chk(count_o == TABLE[i][7:0], "R1 restart count", count_o, TABLE[i][7:0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vecs++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule